// File: doc/BRIEF.md
# Flash Program Pulse Scheduler

This block times the program-enable pulse for each attempt of a flash write loop. A start strobe opens a new programming operation at attempt 1 and fires the first pulse. A retry strobe, issued by the surrounding controller after a failed verify, fires the pulse for the next attempt. The first `EARLY_CNT` attempts use a short pulse made of a head segment followed by a tail segment, with the enable held high across both. Later attempts use one long pulse. An internal divider turns the core clock into a microsecond timebase, and every width is counted in microseconds.

The block counts attempts and raises a limit flag once the count passes the configured ceiling. After that flag is set, retries have no effect. It also adds up the microseconds during which the enable was high, so verify time is not included. It compares this total with the time budget implied by the configured ceiling: each early attempt is worth head plus tail, and each attempt after the early ones is worth one long pulse.

Top module: `flash_pulse_sched`

## Requirements
- R1: After reset `prog_en_o`, `tail_seg_o`, `done_o`, `limit_o` and `over_budget_o` are 0, and `attempt_o` and `prog_us_o` are 0.
- R2: A `start_i` pulse while no pulse is active sets `attempt_o` to 1 and clears `prog_us_o`. If `max_att_i` is at least 1, it also raises `prog_en_o` in the cycle after the strobe.
- R3: For attempts 1 to `EARLY_CNT` (default 6), `prog_en_o` stays high without a gap for (HEAD_US+TAIL_US)·CLK_PER_US cycles. `tail_seg_o` is high for exactly the last TAIL_US·CLK_PER_US of those cycles.
- R4: For attempts above `EARLY_CNT`, `prog_en_o` stays high for LONG_US·CLK_PER_US cycles and `tail_seg_o` stays low.
- R5: In the first cycle with `prog_en_o` low after a pulse, `done_o` is high for exactly one cycle and `attempt_o` has gone up by one.
- R6: `prog_us_o` goes up by one for each microsecond of `prog_en_o` high time. It holds its value while no pulse is active.
- R7: A `retry_i` pulse while idle, with `attempt_o` between 1 and `max_att_i`, raises `prog_en_o` in the next cycle for the current attempt. If `attempt_o` is 0, the retry is ignored.
- R8: `limit_o` is high exactly when `attempt_o` > `max_att_i`. While it is high, `retry_i` starts no pulse and leaves `attempt_o` unchanged.
- R9: `start_i` and `retry_i` are ignored while `prog_en_o` is high. Pulse length, attempt count and `prog_us_o` are unaffected.
- R10: A `start_i` pulse with `max_att_i` = 0 sets `attempt_o` to 1 and clears `prog_us_o`, but fires no pulse.
- R11: `over_budget_o` is high exactly when `prog_us_o` exceeds the budget B(N) for N = `max_att_i`. For N ≤ EARLY_CNT, B(N) = (HEAD_US+TAIL_US)·N. Otherwise, B(N) = (HEAD_US+TAIL_US)·EARLY_CNT + LONG_US·(N−EARLY_CNT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a programming operation at attempt 1 |
| retry_i | input | 1 | Fires the pulse for the current attempt after a failed verify |
| max_att_i | input | ATT_W | Attempt ceiling N |
| prog_en_o | output | 1 | Program-bit enable |
| tail_seg_o | output | 1 | High during the tail segment of an early pulse |
| attempt_o | output | ATT_W+1 | Current attempt number |
| done_o | output | 1 | One-cycle flag after a pulse ends |
| limit_o | output | 1 | Attempt count is above the ceiling |
| prog_us_o | output | ACC_W | Accumulated enable time in microseconds |
| over_budget_o | output | 1 | Accumulated time is above B(N) |

## Verification
The assertions assume three things about the inputs:
- `max_att_i` is stable whenever a pulse is launched. The launch-within-ceiling property relates the attempt count to that input.
- Strobes last one cycle.
- Every configured width is at least one microsecond.

The stimulus changes `max_att_i` only between pulses, and it drives each strobe for one cycle on the falling edge. It provokes over-budget by lowering the ceiling while idle, never by disturbing a running pulse.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_HEAD = 2'd1,
    PS_TAIL = 2'd2,
    PS_LONG = 2'd3
  } pulse_st_e;

  // Time budget in microseconds for a ceiling of n attempts.
  function automatic int unsigned fps_budget_us(
    input int unsigned n,
    input int unsigned early,
    input int unsigned head_us,
    input int unsigned tail_us,
    input int unsigned long_us
  );
    if (n <= early) begin
      return (head_us + tail_us) * n;
    end
    return (head_us + tail_us) * early + long_us * (n - early);
  endfunction

endpackage

// File: rtl/fps_us_tick.sv
module fps_us_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick_o = run_i && (cnt_q == LAST);
  assign cnt_en = clr_i || run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (run_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fps_pulse_fsm.sv
module fps_pulse_fsm
  import fps_pkg::*;
#(
  parameter int HEAD_US = 30,
  parameter int TAIL_US = 10,
  parameter int LONG_US = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic long_i,
  input  logic tick_i,
  output logic active_o,
  output logic tail_o,
  output logic end_o
);
  localparam int MAXW = (LONG_US > HEAD_US) ?
                        ((LONG_US > TAIL_US) ? LONG_US : TAIL_US) :
                        ((HEAD_US > TAIL_US) ? HEAD_US : TAIL_US);
  localparam int UW = $clog2(MAXW + 1);
  localparam logic [UW-1:0] HEAD_LAST = UW'(HEAD_US - 1);
  localparam logic [UW-1:0] TAIL_LAST = UW'(TAIL_US - 1);
  localparam logic [UW-1:0] LONG_LAST = UW'(LONG_US - 1);

  pulse_st_e     st_q, st_d;
  logic [UW-1:0] us_q, us_d;
  logic          reg_en;

  assign active_o = (st_q != PS_IDLE);
  assign tail_o   = (st_q == PS_TAIL);
  assign reg_en   = launch_i || tick_i;

  always_comb begin
    st_d  = st_q;
    us_d  = us_q;
    end_o = 1'b0;
    unique case (st_q)
      PS_IDLE: begin
        if (launch_i) begin
          st_d = long_i ? PS_LONG : PS_HEAD;
          us_d = '0;
        end
      end
      PS_HEAD: begin
        if (tick_i) begin
          if (us_q == HEAD_LAST) begin
            st_d = PS_TAIL;
            us_d = '0;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      PS_TAIL: begin
        if (tick_i) begin
          if (us_q == TAIL_LAST) begin
            st_d  = PS_IDLE;
            us_d  = '0;
            end_o = 1'b1;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      PS_LONG: begin
        if (tick_i) begin
          if (us_q == LONG_LAST) begin
            st_d  = PS_IDLE;
            us_d  = '0;
            end_o = 1'b1;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_IDLE;
      us_q <= '0;
    end else if (reg_en) begin
      st_q <= st_d;
      us_q <= us_d;
    end
  end

  AST_TAIL_AFTER_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tail_o) |-> $past(st_q) == PS_HEAD); // R3

endmodule

// File: rtl/fps_attempt_ctl.sv
module fps_attempt_ctl #(
  parameter int ATT_W     = 10,
  parameter int EARLY_CNT = 6,
  parameter int CNT_W     = ATT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             retry_i,
  input  logic [ATT_W-1:0] max_i,
  input  logic             busy_i,
  input  logic             end_i,
  output logic             launch_o,
  output logic             long_o,
  output logic             clr_o,
  output logic [CNT_W-1:0] attempt_o,
  output logic             done_o,
  output logic             limit_o
);
  localparam logic [CNT_W-1:0] EARLY = CNT_W'(EARLY_CNT);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] att_q, att_d;
  logic             att_en;
  logic             done_q;
  logic             start_ok, retry_ok;

  assign limit_o  = att_q > {1'b0, max_i};
  assign start_ok = start_i && !busy_i;
  assign retry_ok = retry_i && !busy_i && !start_i && !limit_o && (att_q != '0);
  assign launch_o = (start_ok && (max_i != '0)) || retry_ok;
  assign long_o   = start_ok ? (ONE > EARLY) : (att_q > EARLY);
  assign clr_o    = start_ok;
  assign att_en   = start_ok || end_i;

  always_comb begin
    att_d = att_q;
    if (start_ok) begin
      att_d = ONE;
    end else if (end_i) begin
      att_d = att_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q <= '0;
    end else if (att_en) begin
      att_q <= att_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= end_i;
    end
  end

  assign attempt_o = att_q;
  assign done_o    = done_q;

  AST_ATTEMPT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> att_q == $past(att_q) + 1'b1); // R5
  AST_LAUNCH_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> att_q <= {1'b0, max_i}); // R8

endmodule

// File: rtl/fps_time_acc.sv
module fps_time_acc
  import fps_pkg::*;
#(
  parameter int ATT_W     = 10,
  parameter int ACC_W     = 18,
  parameter int EARLY_CNT = 6,
  parameter int HEAD_US   = 30,
  parameter int TAIL_US   = 10,
  parameter int LONG_US   = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [ATT_W-1:0] max_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             over_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_en;
  int unsigned      budget;

  assign acc_en = clr_i || tick_i;

  always_comb begin
    acc_d = acc_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (tick_i && (acc_q != '1)) begin
      acc_d = acc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_comb begin
    budget = fps_budget_us(32'(max_i), int'(EARLY_CNT), int'(HEAD_US),
                           int'(TAIL_US), int'(LONG_US));
  end

  assign over_o = 32'(acc_q) > budget;
  assign acc_o  = acc_q;

endmodule

// File: rtl/flash_pulse_sched.sv
module flash_pulse_sched #(
  parameter int CLK_PER_US = 100,
  parameter int HEAD_US    = 30,
  parameter int TAIL_US    = 10,
  parameter int LONG_US    = 200,
  parameter int EARLY_CNT  = 6,
  parameter int ATT_W      = 10,
  parameter int CNT_W      = ATT_W + 1,
  parameter int ACC_W      = $clog2((HEAD_US + TAIL_US) * EARLY_CNT +
                                    LONG_US * (2 ** ATT_W) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             retry_i,
  input  logic [ATT_W-1:0] max_att_i,
  output logic             prog_en_o,
  output logic             tail_seg_o,
  output logic [CNT_W-1:0] attempt_o,
  output logic             done_o,
  output logic             limit_o,
  output logic [ACC_W-1:0] prog_us_o,
  output logic             over_budget_o
);
  logic rst_meta_q, rst_sync_q;
  logic launch, long_sel, clr_acc, tick, pulse_end, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  fps_us_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .run_i  (active),
    .clr_i  (launch),
    .tick_o (tick)
  );

  fps_attempt_ctl #(.ATT_W(ATT_W), .EARLY_CNT(EARLY_CNT), .CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_i   (start_i),
    .retry_i   (retry_i),
    .max_i     (max_att_i),
    .busy_i    (active),
    .end_i     (pulse_end),
    .launch_o  (launch),
    .long_o    (long_sel),
    .clr_o     (clr_acc),
    .attempt_o (attempt_o),
    .done_o    (done_o),
    .limit_o   (limit_o)
  );

  fps_pulse_fsm #(.HEAD_US(HEAD_US), .TAIL_US(TAIL_US), .LONG_US(LONG_US)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .launch_i (launch),
    .long_i   (long_sel),
    .tick_i   (tick),
    .active_o (active),
    .tail_o   (tail_seg_o),
    .end_o    (pulse_end)
  );

  fps_time_acc #(
    .ATT_W(ATT_W), .ACC_W(ACC_W), .EARLY_CNT(EARLY_CNT),
    .HEAD_US(HEAD_US), .TAIL_US(TAIL_US), .LONG_US(LONG_US)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .clr_i  (clr_acc),
    .tick_i (tick),
    .max_i  (max_att_i),
    .acc_o  (prog_us_o),
    .over_o (over_budget_o)
  );

  assign prog_en_o = active;

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(prog_en_o) |-> done_o); // R5
  AST_TAIL_EARLY_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    tail_seg_o |-> attempt_o <= CNT_W'(EARLY_CNT)); // R3
  AST_ACC_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!prog_en_o && !start_i) |=> $stable(prog_us_o)); // R6
  AST_LIMIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (limit_o && !prog_en_o && !start_i) |=> !prog_en_o); // R8

endmodule

// File: tb/flash_pulse_sched_tb.sv
module flash_pulse_sched_tb;
  localparam int P     = 4;
  localparam int ATT_W = 10;
  localparam int CNT_W = ATT_W + 1;
  localparam int ACC_W = 18;
  localparam int EARLY_HI = 40 * P;
  localparam int TAIL_HI  = 10 * P;
  localparam int LONG_HI  = 200 * P;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             retry_i = 1'b0;
  logic [ATT_W-1:0] max_att_i = '0;
  logic             prog_en_o, tail_seg_o, done_o, limit_o, over_budget_o;
  logic [CNT_W-1:0] attempt_o;
  logic [ACC_W-1:0] prog_us_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  flash_pulse_sched #(.CLK_PER_US(P), .ATT_W(ATT_W), .ACC_W(ACC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .retry_i(retry_i),
    .max_att_i(max_att_i), .prog_en_o(prog_en_o), .tail_seg_o(tail_seg_o),
    .attempt_o(attempt_o), .done_o(done_o), .limit_o(limit_o),
    .prog_us_o(prog_us_o), .over_budget_o(over_budget_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic strobe(input bit s, input bit r);
    @(negedge clk);
    start_i = s; retry_i = r;
    @(negedge clk);
    start_i = 0; retry_i = 0;
  endtask

  // Counts the high cycles of a pulse already running; inject>=0 strobes mid-pulse.
  task automatic run_pulse(output int hi, output int tl, input int inject);
    hi = 0; tl = 0;
    while (prog_en_o && hi < 5000) begin
      hi++;
      if (tail_seg_o) tl++;
      if (hi == inject) begin start_i = 1; retry_i = 1; end
      else begin start_i = 0; retry_i = 0; end
      @(negedge clk);
    end
    start_i = 0; retry_i = 0;
  endtask

  task automatic t_reset();
    chk("R1", "prog_en", int'(prog_en_o), 0);
    chk("R1", "tail", int'(tail_seg_o), 0);
    chk("R1", "attempt", int'(attempt_o), 0);
    chk("R1", "prog_us", int'(prog_us_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "limit", int'(limit_o), 0);
    chk("R1", "over", int'(over_budget_o), 0);
    strobe(0, 1);
    chk("R7", "retry at attempt 0 ignored", int'(prog_en_o), 0);
  endtask

  task automatic t_first();
    int hi, tl;
    max_att_i = 10;
    strobe(1, 0);
    chk("R2", "prog_en after start", int'(prog_en_o), 1);
    chk("R2", "attempt after start", int'(attempt_o), 1);
    chk("R2", "prog_us cleared", int'(prog_us_o), 0);
    run_pulse(hi, tl, -1);
    chk("R3", "early high cycles", hi, EARLY_HI);
    chk("R3", "tail cycles", tl, TAIL_HI);
    chk("R5", "done after pulse", int'(done_o), 1);
    chk("R5", "attempt step", int'(attempt_o), 2);
    chk("R6", "prog_us after pulse", int'(prog_us_o), 40);
    @(negedge clk);
    chk("R5", "done one cycle", int'(done_o), 0);
    repeat (20) @(negedge clk);
    chk("R6", "prog_us idle hold", int'(prog_us_o), 40);
  endtask

  task automatic t_to_long();
    int hi, tl;
    for (int a = 2; a <= 6; a++) begin
      strobe(0, 1);
      chk("R7", "retry launches", int'(prog_en_o), 1);
      run_pulse(hi, tl, -1);
      chk("R3", "early width", hi, EARLY_HI);
    end
    strobe(0, 1);
    chk("R4", "attempt 7 running", int'(attempt_o), 7);
    run_pulse(hi, tl, -1);
    chk("R4", "long width", hi, LONG_HI);
    chk("R4", "no tail in long", tl, 0);
    chk("R6", "prog_us total", int'(prog_us_o), 440);
    chk("R5", "attempt after long", int'(attempt_o), 8);
  endtask

  task automatic t_limit();
    @(negedge clk);
    max_att_i = 7;
    @(negedge clk);
    chk("R8", "limit set", int'(limit_o), 1);
    chk("R11", "budget equal not over", int'(over_budget_o), 0);
    strobe(0, 1);
    for (int i = 0; i < 10; i++) begin
      chk("R8", "retry blocked", int'(prog_en_o), 0);
      @(negedge clk);
    end
    chk("R8", "attempt held", int'(attempt_o), 8);
    max_att_i = 6;
    @(negedge clk);
    chk("R11", "over budget", int'(over_budget_o), 1);
    max_att_i = 10;
    @(negedge clk);
    chk("R8", "limit clear", int'(limit_o), 0);
    chk("R11", "within budget", int'(over_budget_o), 0);
  endtask

  task automatic t_busy();
    int hi, tl;
    strobe(1, 0);
    run_pulse(hi, tl, 50);
    chk("R9", "width with strobes", hi, EARLY_HI);
    chk("R9", "attempt count", int'(attempt_o), 2);
    chk("R9", "prog_us not cleared", int'(prog_us_o), 40);
  endtask

  task automatic t_zero();
    max_att_i = 0;
    strobe(1, 0);
    for (int i = 0; i < 10; i++) begin
      chk("R10", "no pulse at zero ceiling", int'(prog_en_o), 0);
      @(negedge clk);
    end
    chk("R10", "attempt", int'(attempt_o), 1);
    chk("R10", "prog_us cleared", int'(prog_us_o), 0);
    chk("R8", "limit at zero", int'(limit_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first();
    t_to_long();
    t_limit();
    t_busy();
    t_zero();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule